// File: doc/BRIEF.md
# Factory Calibration Value Generator

This block turns four 16-bit factory fuse words into per-sensor 12-bit calibration codes for a thermal sensor controller. On a start pulse it captures the fuse words, a sensor count, and the linear-conversion coefficients (an offset in millidegrees and a scale). It then works through the sensors one at a time. For each sensor it converts the factory raw reading to a temperature and compares that with the ambient temperature recorded at test. It scales the error back into code units and subtracts it from the mid-scale code 0x800.

Each code that fits in 12 bits is issued as a masked write into a packed calibration word array, two sensors per 32-bit word. The mask confines the write so that a read-modify-write at the register file leaves the neighbouring half untouched. Codes that do not fit are not written, so the register keeps its default, and the sensor is flagged as skipped. A done pulse marks the end of the run. The skipped-sensor vector then holds until the next start.

Top module: `fuse_cal_gen`

## Requirements
- R1: After reset, wr_en_o and done_o are low and skip_o is all zero.
- R2: The ambient temperature in millidegrees is fuse word 0 bits [11:0] times 100. The upper four bits of word 0 do not contribute to it.
- R3: When fuse word 0 (fuse_i[15:0]) is zero at start, no write is issued. done_o pulses in the cycle after start, and skip_o has bit i set for every sensor i below the effective count.
- R4: The raw reading of sensor s, for s in 0..2, is bits [11:0] of fuse word s+1, where word w sits at fuse_i[16w+15:16w].
- R5: The raw reading of sensor 3 takes bits [15:12] of words 1, 2 and 3 as its bits [3:0], [7:4] and [11:8].
- R6: The code is 2048 − ((offset − reading·scale/10 − ambient)·10/scale). Each division is signed and truncates toward zero.
- R7: A code that is negative or above 4095 causes no write, and sets bit i of skip_o.
- R8: A write for sensor i drives wr_addr_o = i/2. When i is even, the write places the code in bits [11:0] with mask 0x00000FFF. When i is odd, the code goes in bits [27:16] with mask 0x0FFF0000. All other data bits are zero.
- R9: Sensors are handled in ascending index, from 0 up to the effective count minus one. The effective count is count_i, except that 0 is taken as 1 and values above 4 are taken as 4.
- R10: done_o is a one-cycle pulse after the last sensor is handled. skip_o then stays unchanged until the next accepted start.
- R11: A start_i pulse that arrives while a run is in progress is ignored.
- R12: wr_en_o is high for one cycle per written sensor, never two cycles back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| fuse_i | input | 64 | Four fuse words, word w at [16w+15:16w] |
| count_i | input | 3 | Number of sensors (1..4, clamped) |
| offset_i | input | 24 | Signed conversion offset in millidegrees |
| scale_i | input | 12 | Conversion scale (non-zero) |
| wr_en_o | output | 1 | Calibration word write strobe |
| wr_addr_o | output | 1 | Calibration word index |
| wr_data_o | output | 32 | Write data, code in the sensor's half |
| wr_mask_o | output | 32 | Write bit mask, 12 ones in the sensor's half |
| done_o | output | 1 | Run-complete pulse |
| skip_o | output | 4 | Per-sensor skipped flags |

## Verification
The cases cover these patterns:
- Mid-range readings with two coefficient sets, where the codes land near 0x800.
- A four-sensor run with distinct top nibbles in words 1 to 3, which separates the assembly of sensor 3 from the plain low-field sensors.
- A zero reading and a hot ambient with a full-scale reading, which push the code below zero and above 4095 and so exercise the skip path.
- A negative error that is not a multiple of the scale, which tells truncation toward zero from floor division.
- A zeroed word 0, which exercises the abort path.
- A word 0 with only its top nibble set, which shows the abort test is not confused with the ambient field.
- Counts of 0 and 7, which exercise the clamping.
- A second start with an abort pattern during a run, which must leave that run's writes and flags unchanged.

// File: rtl/fcal_pkg.sv
package fcal_pkg;
  localparam int unsigned N_SENS  = 4;
  localparam int unsigned CAL_W   = 12;
  localparam int unsigned CAL_MID = 2048;
  localparam int unsigned AMB_MUL = 100;
  localparam int unsigned DEC_DIV = 10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_D1,
    ST_D1W,
    ST_D2,
    ST_D2W,
    ST_CHK,
    ST_WR,
    ST_NXT,
    ST_DONE
  } st_e;
endpackage

// File: rtl/fcal_extract.sv
module fcal_extract #(
  parameter int unsigned FUSE_W = 16,
  parameter int unsigned CAL_W  = 12,
  parameter int unsigned N      = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [N*FUSE_W-1:0] fuse_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [CAL_W-1:0]    reading_o
);
  localparam int unsigned NIB = CAL_W / (N - 1);

  logic [CAL_W-1:0] rd_lo [N-1];
  logic [CAL_W-1:0] rd_last;

  generate
    for (genvar s = 0; s < N - 1; s++) begin : g_direct
      assign rd_lo[s] = fuse_i[(s+1)*FUSE_W +: CAL_W];
    end
    // last sensor: top nibble of each of words 1..N-1, low word first
    for (genvar k = 0; k < N - 1; k++) begin : g_nib
      assign rd_last[k*NIB +: NIB] = fuse_i[(k+2)*FUSE_W-1 -: NIB];
    end
  endgenerate

  always_comb begin
    reading_o = rd_last;
    for (int s = 0; s < N - 1; s++) begin
      if (idx_i == IDX_W'(s)) reading_o = rd_lo[s];
    end
  end
endmodule

// File: rtl/fcal_div.sv
module fcal_div #(
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                go_i,
  input  logic signed [W-1:0] num_i,
  input  logic signed [W-1:0] den_i,
  output logic                done_o,
  output logic signed [W-1:0] quo_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          neg_q;
  logic [W-1:0]  num_abs;
  logic [W-1:0]  den_abs;
  logic [W:0]    shf;
  logic [W:0]    trial;

  assign num_abs = num_i[W-1] ? W'(-num_i) : W'(num_i);
  assign den_abs = den_i[W-1] ? W'(-den_i) : W'(den_i);
  assign shf     = {rem_q[W-1:0], quo_q[W-1]};
  assign trial   = shf - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      neg_q  <= 1'b0;
      done_o <= 1'b0;
    end else if (go_i) begin
      rem_q  <= '0;
      quo_q  <= num_abs;
      den_q  <= den_abs;
      cnt_q  <= CW'(W);
      run_q  <= 1'b1;
      neg_q  <= num_i[W-1] ^ den_i[W-1];
      done_o <= 1'b0;
    end else if (run_q) begin
      if (!trial[W]) begin
        rem_q <= trial;
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shf;
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q  <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  // magnitude quotient carries the truncation toward zero
  assign quo_o = neg_q ? -$signed(quo_q) : $signed(quo_q);

  a_r6_div_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_no_relaunch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !go_i);
endmodule

// File: rtl/fcal_pack.sv
module fcal_pack #(
  parameter int unsigned CAL_W  = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned ADDR_W = 1
) (
  input  logic [CAL_W-1:0]  cal_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] mask_o
);
  localparam int unsigned HALF = DATA_W / 2;

  assign addr_o = ADDR_W'(idx_i >> 1);

  generate
    for (genvar l = 0; l < 2; l++) begin : g_lane
      logic hit;
      assign hit = (idx_i[0] == 1'(l));
      assign data_o[l*HALF +: HALF] = hit ? HALF'(cal_i) : '0;
      assign mask_o[l*HALF +: HALF] = hit ? HALF'({CAL_W{1'b1}}) : '0;
    end
  endgenerate
endmodule

// File: rtl/fuse_cal_gen.sv
module fuse_cal_gen
  import fcal_pkg::*;
#(
  parameter int unsigned FUSE_W = 16,
  parameter int unsigned OFS_W  = 24,
  parameter int unsigned SCL_W  = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [N_SENS*FUSE_W-1:0]      fuse_i,
  input  logic [$clog2(N_SENS+1)-1:0]   count_i,
  input  logic signed [OFS_W-1:0]       offset_i,
  input  logic [SCL_W-1:0]              scale_i,
  output logic                          wr_en_o,
  output logic [((N_SENS>2)?$clog2(N_SENS)-1:1)-1:0] wr_addr_o,
  output logic [DATA_W-1:0]             wr_data_o,
  output logic [DATA_W-1:0]             wr_mask_o,
  output logic                          done_o,
  output logic [N_SENS-1:0]             skip_o
);
  localparam int unsigned N      = N_SENS;
  localparam int unsigned IDX_W  = $clog2(N);
  localparam int unsigned CNT_W  = $clog2(N + 1);
  localparam int unsigned ADDR_W = (N > 2) ? IDX_W - 1 : 1;
  localparam int unsigned DIV_W  = OFS_W + 8;

  st_e                      st_q;
  logic [N*FUSE_W-1:0]      fuse_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [CNT_W-1:0]         cnt_w;
  logic signed [OFS_W-1:0]  off_q;
  logic [SCL_W-1:0]         scl_q;
  logic signed [DIV_W-1:0]  amb_q;
  logic signed [DIV_W-1:0]  acc_q;
  logic [IDX_W-1:0]         idx_q;
  logic [N-1:0]             skip_q;
  logic [N-1:0]             abort_mask;
  logic [CAL_W-1:0]         rd;
  logic [DIV_W-1:0]         prod_w;
  logic signed [DIV_W-1:0]  off_ext;
  logic                     div_go;
  logic signed [DIV_W-1:0]  div_num;
  logic signed [DIV_W-1:0]  div_den;
  logic                     div_done;
  logic signed [DIV_W-1:0]  div_q;
  logic                     fits;
  logic                     last;

  always_comb begin
    if (count_i == '0)              cnt_w = CNT_W'(1);
    else if (count_i > CNT_W'(N))   cnt_w = CNT_W'(N);
    else                            cnt_w = count_i;
  end

  always_comb begin
    for (int i = 0; i < N; i++) abort_mask[i] = (CNT_W'(i) < cnt_w);
  end

  fcal_extract #(
    .FUSE_W(FUSE_W), .CAL_W(CAL_W), .N(N), .IDX_W(IDX_W)
  ) u_extract (
    .fuse_i   (fuse_q),
    .idx_i    (idx_q),
    .reading_o(rd)
  );

  assign prod_w  = DIV_W'(rd) * DIV_W'(scl_q);
  assign off_ext = $signed({{(DIV_W-OFS_W){off_q[OFS_W-1]}}, off_q});
  assign div_go  = (st_q == ST_D1) || (st_q == ST_D2);
  assign div_num = (st_q == ST_D1) ? $signed(prod_w) : ((acc_q <<< 3) + (acc_q <<< 1));
  assign div_den = (st_q == ST_D1) ? $signed(DIV_W'(DEC_DIV)) : $signed(DIV_W'(scl_q));

  fcal_div #(.W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (div_go),
    .num_i (div_num),
    .den_i (div_den),
    .done_o(div_done),
    .quo_o (div_q)
  );

  assign fits = (acc_q[DIV_W-1:CAL_W] == '0);
  assign last = ({1'b0, idx_q} == CNT_W'(cnt_q - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fuse_q <= '0;
      cnt_q  <= '0;
      off_q  <= '0;
      scl_q  <= '0;
      amb_q  <= '0;
      acc_q  <= '0;
      idx_q  <= '0;
      skip_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          fuse_q <= fuse_i;
          cnt_q  <= cnt_w;
          off_q  <= offset_i;
          scl_q  <= scale_i;
          idx_q  <= '0;
          amb_q  <= $signed(DIV_W'(fuse_i[CAL_W-1:0]) * DIV_W'(AMB_MUL));
          if (fuse_i[FUSE_W-1:0] == '0) begin
            skip_q <= abort_mask;
            st_q   <= ST_DONE;
          end else begin
            skip_q <= '0;
            st_q   <= ST_D1;
          end
        end
        ST_D1:  st_q <= ST_D1W;
        ST_D1W: if (div_done) begin
          acc_q <= off_ext - div_q - amb_q;
          st_q  <= ST_D2;
        end
        ST_D2:  st_q <= ST_D2W;
        ST_D2W: if (div_done) begin
          acc_q <= $signed(DIV_W'(CAL_MID)) - div_q;
          st_q  <= ST_CHK;
        end
        ST_CHK: begin
          if (fits) st_q <= ST_WR;
          else begin
            skip_q[idx_q] <= 1'b1;
            st_q          <= ST_NXT;
          end
        end
        ST_WR:  st_q <= ST_NXT;
        ST_NXT: begin
          if (last) st_q <= ST_DONE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_D1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  fcal_pack #(
    .CAL_W(CAL_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_pack (
    .cal_i (acc_q[CAL_W-1:0]),
    .idx_i (idx_q),
    .addr_o(wr_addr_o),
    .data_o(wr_data_o),
    .mask_o(wr_mask_o)
  );

  assign wr_en_o = (st_q == ST_WR);
  assign done_o  = (st_q == ST_DONE);
  assign skip_o  = skip_q;

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_write_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  a_r8_mask_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $countones(wr_mask_o) == CAL_W);
  a_r8_data_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o & ~wr_mask_o) == '0);
  a_r3_abort_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && fuse_i[FUSE_W-1:0] == '0) |=> (done_o && !wr_en_o));
  a_r10_skip_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> $stable(skip_o));
  a_r11_busy_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && start_i) |=> $stable(cnt_q));
endmodule

// File: tb/fuse_cal_gen_bench.sv
module fuse_cal_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] fuse_i = '0;
  logic [2:0]  count_i = 3'd1;
  logic signed [23:0] offset_i = '0;
  logic [11:0] scale_i = 12'd1;
  logic        wr_en_o;
  logic [0:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic [31:0] wr_mask_o;
  logic        done_o;
  logic [3:0]  skip_o;

  always #5 clk = ~clk;

  fuse_cal_gen u_fuse_cal_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .fuse_i(fuse_i),
    .count_i(count_i), .offset_i(offset_i), .scale_i(scale_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_mask_o(wr_mask_o), .done_o(done_o), .skip_o(skip_o)
  );

  typedef struct {
    logic [0:0]  addr;
    logic [31:0] data;
    logic [31:0] mask;
    int          sens;
  } wr_t;

  wr_t        exp_q[$];
  logic [3:0] exp_skip = '0;
  int         checks = 0;
  int         errors = 0;
  int         done_cnt = 0;
  int         cyc = 0;
  bit         prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    wr_t e;
    if (rst_n) begin
      if (wr_en_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected write", longint'(wr_data_o), 0);
        else begin
          e = exp_q.pop_front();
          chk(wr_addr_o == e.addr, "R8", "write address", longint'(wr_addr_o), longint'(e.addr));
          if (e.sens == 3)
            chk(wr_data_o == e.data, "R5", "sensor3 data", longint'(wr_data_o), longint'(e.data));
          else
            chk(wr_data_o == e.data, "R4", "sensor data", longint'(wr_data_o), longint'(e.data));
          chk(wr_mask_o == e.mask, "R8", "write mask", longint'(wr_mask_o), longint'(e.mask));
        end
      end
      if (done_o) begin
        chk(skip_o == exp_skip, "R7", "skip vector at done", longint'(skip_o), longint'(exp_skip));
        chk(exp_q.size() == 0, "R9", "writes outstanding at done", exp_q.size(), 0);
        if (prev_done) chk(1'b0, "R10", "done wider than one cycle", 2, 1);
        done_cnt++;
      end
      prev_done = done_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input logic [15:0] w0, w1, w2, w3, input int cnt,
                          input int off, input int scl, input bit poke);
    longint amb, rd, conv, q, cal;
    int ec, d0;
    logic [15:0] w [4];
    wr_t it;
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    ec = (cnt < 1) ? 1 : ((cnt > 4) ? 4 : cnt);
    exp_skip = '0;
    amb = longint'(w0 & 16'h0FFF) * 100;
    for (int i = 0; i < ec; i++) begin
      if (w0 == 16'h0) exp_skip[i] = 1'b1;
      else begin
        if (i < 3) rd = longint'(w[i+1] & 16'h0FFF);
        else rd = longint'(w[1] >> 12) | (longint'(w[2] >> 12) << 4) | (longint'(w[3] >> 12) << 8);
        conv = longint'(off) - (rd * scl) / 10;
        q    = ((conv - amb) * 10) / scl;
        cal  = 2048 - q;
        if (cal >= 0 && cal <= 4095) begin
          it.addr = 1'(i / 2);
          it.data = 32'(cal) << (16 * (i % 2));
          it.mask = 32'h0FFF << (16 * (i % 2));
          it.sens = i;
          exp_q.push_back(it);
        end else exp_skip[i] = 1'b1;
      end
    end
    d0 = done_cnt;
    @(posedge clk); #1;
    fuse_i = {w3, w2, w1, w0}; count_i = 3'(cnt); offset_i = 24'(off); scale_i = 12'(scl);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (poke) begin
      // R11: abort pattern while busy must be ignored
      repeat (4) @(posedge clk); #1;
      fuse_i = '0; count_i = 3'd1; start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    wait (done_cnt == d0 + 1);
    repeat (10) @(negedge clk);
    chk(skip_o == exp_skip, "R10", "skip held after done", longint'(skip_o), longint'(exp_skip));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en_o && !done_o && skip_o == '0, "R1", "reset outputs",
        longint'({wr_en_o, done_o, skip_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wr_en_o && !done_o && skip_o == '0, "R1", "idle outputs",
        longint'({wr_en_o, done_o, skip_o}), 0);
    // R6 mid-range, two sensors
    run_case(16'h00FA, 16'h0970, 16'h0900, 16'h0000, 2, 187744, 672, 1'b0);
    // R5 four sensors, distinct nibbles
    run_case(16'h0118, 16'h5A10, 16'hBA40, 16'h3A00, 4, 263655, 810, 1'b0);
    // R7 low reading underflows, others valid
    run_case(16'h00FA, 16'h0000, 16'h0FFF, 16'h0970, 3, 187744, 672, 1'b0);
    // R7 hot ambient overflows
    run_case(16'h0FFF, 16'h0FFF, 16'h0000, 16'h0000, 1, 187744, 672, 1'b0);
    // R3 abort
    run_case(16'h0000, 16'h0970, 16'h0900, 16'h0800, 3, 187744, 672, 1'b0);
    // R2 top nibble only: not abort, ambient 0; R9 count 0 -> 1
    run_case(16'hF000, 16'h0900, 16'h0800, 16'h0700, 0, 187744, 672, 1'b0);
    // R9 count 7 -> 4, R11 start while busy
    run_case(16'h00C8, 16'h7880, 16'h2900, 16'h9950, 7, 251086, 1130, 1'b1);
    // R6 negative error not a multiple of scale
    run_case(16'h0190, 16'h0600, 16'h0000, 16'h0000, 1, 217000, 1211, 1'b0);
    // R11 again on a two-word run
    run_case(16'h00FA, 16'h0970, 16'h0900, 16'h0000, 2, 187744, 672, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule